// File: doc/BRIEF.md
# Coalescing Write Buffer with Read Forwarding

This block sits between a processor and the next memory level and holds writes that have not yet been sent on. Each slot covers one downstream line of `WORDS` consecutive words and keeps one valid flag per word. Writes arrive one word at a time, in program order, on a valid/ready stream. A write to a line that is already held is folded into that slot. A write to any other line opens a fresh slot. The producer must hold `wr_valid`, `wr_addr` and `wr_data` until it sees `wr_ready`. A write is taken on any edge where both are high.

A read is a single-cycle query on plain pins, and it sees the buffer as it stood before that edge. The block answers with exactly one of three results. Bypass means the read may go to memory ahead of the held writes. Forward means the word is returned from the buffer at once. Stall means the requester must retry. The first screen compares only the low `PART_BITS` of the line address, so it is conservative. A full compare plus the word's valid flag then decides whether the read is forwarded.

Slots drain through a valid/ready output. Downstream refuses lines per bank through `dn_bank_busy`, where the bank is the low bits of the line address. Slots in a busy bank are passed over, and the oldest slot that is still eligible is offered. The offer may change from one cycle to the next until it is accepted. Downstream uses only the values present on the edge where `dn_valid` and `dn_ready` are both high.

Top module: `wbuf_top`

## Requirements
- R1: After reset the buffer is empty: `dn_valid` is 0, `wr_ready` is 1, and every read query returns bypass.
- R2: A write to a line already held merges into that slot and opens no new slot. A second write to the same word replaces the earlier data.
- R3: A read whose low `PART_BITS` line-address bits match no held slot returns bypass. A read that matches a slot on those bits but not on the full line returns stall.
- R4: A read whose full line matches a slot in which the requested word is valid returns forward in the same cycle, with the latest data written to that word on `rd_data`.
- R5: A read whose full line matches a slot in which the requested word is not valid returns stall.
- R6: When every slot is in use, `wr_ready` is 0 for a write to a line that is not held and 1 for a write to a line that is held.
- R7: A slot whose bank (line address bits [BANK_W-1:0]) has its `dn_bank_busy` bit set is never offered. A later slot in a free bank may drain ahead of it, and `dn_valid` is 0 when only blocked slots remain.
- R8: Among the slots that may be offered, the one allocated earliest is offered first.
- R9: A transfer carries the line address and the slot's words, with `dn_be` bits [w*BYTES +: BYTES] all set for each written word w and clear for the others. Word w sits at `dn_data[w*DATA_W +: DATA_W]`. The slot becomes free on the handshake.
- R10: A write to the line whose slot is transferred on the same edge starts a fresh slot that holds only that new word, and neither write is lost.
- R11: While `rd_valid` is 1, exactly one of `rd_bypass`, `rd_fwd` and `rd_stall` is 1. While `rd_valid` is 0, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Write can be taken |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Read query present |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_bypass | output | 1 | Read may pass the held writes |
| rd_fwd | output | 1 | Read served from the buffer |
| rd_stall | output | 1 | Read must wait |
| rd_data | output | DATA_W | Forwarded word |
| dn_valid | output | 1 | Line offered downstream |
| dn_ready | input | 1 | Downstream accepts the offer |
| dn_line | output | ADDR_W-log2(WORDS) | Line address of the offer |
| dn_data | output | WORDS*DATA_W | Line data, word 0 in the low bits |
| dn_be | output | WORDS*DATA_W/8 | Byte enables of the offer |
| dn_bank_busy | input | BANKS | Per-bank refusal from downstream |

## Verification
The bench builds the block with four slots, four 16-bit words per line, a 12-bit word address, a 3-bit partial compare and two banks. With four slots, the full-buffer case comes within a handful of writes. With a 3-bit partial compare, two distinct lines can be picked that collide on the cheap screen and so exercise the stall path. With two banks, one bank can be blocked so that the drain order visibly departs from allocation order and then resumes oldest-first. The same-edge transfer-and-write case is driven directly, and the scoreboard checks both resulting transfers.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_BYPASS = 2'd1,
    RD_FWD    = 2'd2,
    RD_STALL  = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/wbuf_entry.sv
module wbuf_entry #(
  parameter int LINE_W = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             alloc_i,
  input  logic                             merge_i,
  input  logic                             retire_i,
  input  logic [LINE_W-1:0]                line_i,
  input  logic [$clog2(WORDS)-1:0]         off_i,
  input  logic [DATA_W-1:0]                data_i,
  output logic                             valid_o,
  output logic [LINE_W-1:0]                line_o,
  output logic [WORDS-1:0]                 wmask_o,
  output logic [WORDS-1:0][DATA_W-1:0]     data_o
);
  localparam int OFF_W = $clog2(WORDS);

  logic                         valid_q;
  logic [LINE_W-1:0]            line_q;
  logic [WORDS-1:0]             wmask_q;
  logic [WORDS-1:0]             word_sel;
  logic [WORDS-1:0][DATA_W-1:0] data_q;

  assign word_sel = WORDS'(1) << off_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      line_q  <= '0;
      wmask_q <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      line_q  <= line_i;
      wmask_q <= word_sel;
    end else if (merge_i) begin
      wmask_q <= wmask_q | word_sel;
    end else if (retire_i) begin
      valid_q <= 1'b0;
      wmask_q <= '0;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q[w] <= '0;
      else if ((alloc_i || merge_i) && off_i == OFF_W'(w)) data_q[w] <= data_i;
    end
  end

  assign valid_o = valid_q;
  assign line_o  = line_q;
  assign wmask_o = wmask_q;
  assign data_o  = data_q;

  // R2: a merge only lands in a live slot
  assert_merge_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    merge_i |-> valid_q);
  // R10: a slot leaving on this edge is never merged into
  assert_no_merge_retire_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(merge_i && retire_i));
  // R9: a live slot always holds at least one word
  assert_live_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (wmask_q != '0));
endmodule

// File: rtl/wbuf_age_arb.sv
module wbuf_age_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_i,
  input  logic [N-1:0] elig_i,
  output logic [N-1:0] grant_o
);
  // older_q[i][j] set: slot i was allocated before slot j
  logic [N-1:0] older_q [N];
  logic [N-1:0] blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (alloc_i[k]) begin
          for (int j = 0; j < N; j++) begin
            if (j != k) begin
              older_q[k][j] <= 1'b0;
              older_q[j][k] <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (elig_i[j] && older_q[j][i]) blocked[i] = 1'b1;
      end
    end
    grant_o = elig_i & ~blocked;
  end

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  assert_grant_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_i != '0) |-> (grant_o != '0));
  assert_single_alloc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_i));
endmodule

// File: rtl/wbuf_lookup.sv
module wbuf_lookup
  import wbuf_pkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int LINE_W    = 8,
  parameter int WORDS     = 4,
  parameter int DATA_W    = 32,
  parameter int PART_BITS = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     rd_valid_i,
  input  logic [LINE_W-1:0]                        rd_line_i,
  input  logic [$clog2(WORDS)-1:0]                 rd_off_i,
  input  logic [ENTRIES-1:0]                       ent_valid_i,
  input  logic [ENTRIES-1:0][LINE_W-1:0]           ent_line_i,
  input  logic [ENTRIES-1:0][WORDS-1:0]            ent_wmask_i,
  input  logic [ENTRIES-1:0][WORDS-1:0][DATA_W-1:0] ent_data_i,
  output logic                                     bypass_o,
  output logic                                     fwd_o,
  output logic                                     stall_o,
  output logic [DATA_W-1:0]                        data_o
);
  logic [ENTRIES-1:0] part_hit;
  logic [ENTRIES-1:0] full_hit;
  logic               word_ok;
  rd_kind_e           kind;

  always_comb begin
    word_ok = 1'b0;
    data_o  = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      part_hit[e] = ent_valid_i[e] &&
                    (ent_line_i[e][PART_BITS-1:0] == rd_line_i[PART_BITS-1:0]);
      full_hit[e] = ent_valid_i[e] && (ent_line_i[e] == rd_line_i);
      if (full_hit[e]) begin
        word_ok = word_ok | ent_wmask_i[e][rd_off_i];
        data_o  = data_o  | ent_data_i[e][rd_off_i];
      end
    end
    if (!rd_valid_i)          kind = RD_NONE;
    else if (part_hit == '0)  kind = RD_BYPASS;
    else if (word_ok)         kind = RD_FWD;
    else                      kind = RD_STALL;
  end

  assign bypass_o = (kind == RD_BYPASS);
  assign fwd_o    = (kind == RD_FWD);
  assign stall_o  = (kind == RD_STALL);

  assert_outcome_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_i |-> $onehot({bypass_o, fwd_o, stall_o}));
  assert_outcome_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |-> !(bypass_o || fwd_o || stall_o));
  // R3: bypass never granted while a full line match exists
  assert_bypass_safe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_o |-> (full_hit == '0));
  // R2: coalescing keeps at most one slot per line
  assert_line_unique_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(full_hit));
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int WORDS     = 4,
  parameter int ENTRIES   = 8,
  parameter int PART_BITS = 4,
  parameter int BANKS     = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_valid,
  output logic                                 wr_ready,
  input  logic [ADDR_W-1:0]                    wr_addr,
  input  logic [DATA_W-1:0]                    wr_data,
  input  logic                                 rd_valid,
  input  logic [ADDR_W-1:0]                    rd_addr,
  output logic                                 rd_bypass,
  output logic                                 rd_fwd,
  output logic                                 rd_stall,
  output logic [DATA_W-1:0]                    rd_data,
  output logic                                 dn_valid,
  input  logic                                 dn_ready,
  output logic [ADDR_W-$clog2(WORDS)-1:0]      dn_line,
  output logic [WORDS*DATA_W-1:0]              dn_data,
  output logic [WORDS*(DATA_W/8)-1:0]          dn_be,
  input  logic [BANKS-1:0]                     dn_bank_busy
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int BANK_W = $clog2(BANKS);
  localparam int BYTES  = DATA_W / 8;

  logic [ENTRIES-1:0]                        e_valid;
  logic [ENTRIES-1:0][LINE_W-1:0]            e_line;
  logic [ENTRIES-1:0][WORDS-1:0]             e_wmask;
  logic [ENTRIES-1:0][WORDS-1:0][DATA_W-1:0] e_data;

  logic [LINE_W-1:0] wr_line;
  logic [OFF_W-1:0]  wr_off;
  logic [ENTRIES-1:0] line_eq, hit_keep, hit_reuse, free_oh;
  logic [ENTRIES-1:0] merge_v, alloc_v, elig, grant, fire;
  logic               wr_acc;

  assign wr_line = wr_addr[ADDR_W-1:OFF_W];
  assign wr_off  = wr_addr[OFF_W-1:0];

  always_comb begin
    logic found;
    found   = 1'b0;
    free_oh = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      line_eq[e] = e_valid[e] && (e_line[e] == wr_line);
      elig[e]    = e_valid[e] && !dn_bank_busy[e_line[e][BANK_W-1:0]];
      if (!e_valid[e] && !found) begin
        free_oh[e] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign fire      = grant & {ENTRIES{dn_ready}};
  assign hit_keep  = line_eq & ~fire;
  assign hit_reuse = line_eq & fire;
  assign wr_ready  = (line_eq != '0) || (e_valid != {ENTRIES{1'b1}});
  assign wr_acc    = wr_valid && wr_ready;
  assign merge_v   = wr_acc ? hit_keep : '0;

  always_comb begin
    alloc_v = '0;
    if (wr_acc && hit_keep == '0) alloc_v = (hit_reuse != '0) ? hit_reuse : free_oh;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    wbuf_entry #(.LINE_W(LINE_W), .WORDS(WORDS), .DATA_W(DATA_W)) entry_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_i  (alloc_v[g]),
      .merge_i  (merge_v[g]),
      .retire_i (fire[g]),
      .line_i   (wr_line),
      .off_i    (wr_off),
      .data_i   (wr_data),
      .valid_o  (e_valid[g]),
      .line_o   (e_line[g]),
      .wmask_o  (e_wmask[g]),
      .data_o   (e_data[g])
    );
  end

  wbuf_age_arb #(.N(ENTRIES)) arb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .alloc_i (alloc_v),
    .elig_i  (elig),
    .grant_o (grant)
  );

  wbuf_lookup #(
    .ENTRIES(ENTRIES), .LINE_W(LINE_W), .WORDS(WORDS),
    .DATA_W(DATA_W), .PART_BITS(PART_BITS)
  ) lookup_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid_i  (rd_valid),
    .rd_line_i   (rd_addr[ADDR_W-1:OFF_W]),
    .rd_off_i    (rd_addr[OFF_W-1:0]),
    .ent_valid_i (e_valid),
    .ent_line_i  (e_line),
    .ent_wmask_i (e_wmask),
    .ent_data_i  (e_data),
    .bypass_o    (rd_bypass),
    .fwd_o       (rd_fwd),
    .stall_o     (rd_stall),
    .data_o      (rd_data)
  );

  logic [LINE_W-1:0]            sel_line;
  logic [WORDS-1:0]             sel_mask;
  logic [WORDS-1:0][DATA_W-1:0] sel_data;

  always_comb begin
    sel_line = '0;
    sel_mask = '0;
    sel_data = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (grant[e]) begin
        sel_line = sel_line | e_line[e];
        sel_mask = sel_mask | e_wmask[e];
        sel_data = sel_data | e_data[e];
      end
    end
  end

  assign dn_valid = (grant != '0);
  assign dn_line  = sel_line;
  assign dn_data  = sel_data;
  for (genvar w = 0; w < WORDS; w++) begin : g_be
    assign dn_be[w*BYTES +: BYTES] = {BYTES{sel_mask[w]}};
  end

  assert_bank_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> !dn_bank_busy[dn_line[BANK_W-1:0]]);
  assert_be_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_be != '0));
  assert_slot_freed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready && !wr_valid) |=> ((e_valid & $past(grant)) == '0));
  assert_write_unique_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $onehot0(line_eq));
endmodule

// File: tb/wbuf_top_tb_top.sv
`timescale 1ns/1ps
module wbuf_top_tb_top;
  localparam int ADDR_W = 12, DATA_W = 16, WORDS = 4, ENTRIES = 4;
  localparam int PART_BITS = 3, BANKS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_valid = 1'b0, dn_ready = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [BANKS-1:0]  dn_bank_busy = '0;
  logic wr_ready, rd_bypass, rd_fwd, rd_stall, dn_valid;
  logic [DATA_W-1:0] rd_data;
  logic [9:0]  dn_line;
  logic [63:0] dn_data;
  logic [7:0]  dn_be;

  always #4 clk = ~clk;

  wbuf_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .ENTRIES(ENTRIES),
             .PART_BITS(PART_BITS), .BANKS(BANKS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_bypass(rd_bypass), .rd_fwd(rd_fwd), .rd_stall(rd_stall), .rd_data(rd_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_line(dn_line), .dn_data(dn_data),
    .dn_be(dn_be), .dn_bank_busy(dn_bank_busy));

  typedef struct {
    logic [9:0]  line;
    logic [63:0] data;
    logic [63:0] dmask;
    logic [7:0]  be;
  } xfer_t;

  xfer_t exp_q[$];
  int tests = 0, fails = 0, n_xfer = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [9:0] line, input logic [15:0] w0, w1, w2, w3,
                          input logic [3:0] vm);
    xfer_t t;
    t.line = line;
    t.data = {w3, w2, w1, w0};
    t.dmask = '0;
    t.be = '0;
    for (int w = 0; w < 4; w++) begin
      if (vm[w]) begin
        t.dmask[w*16 +: 16] = 16'hFFFF;
        t.be[w*2 +: 2] = 2'b11;
      end
    end
    t.data = t.data & t.dmask;
    exp_q.push_back(t);
  endtask

  // monitor: evaluates each handshake just before the edge that completes it
  always @(negedge clk) begin
    #3;
    if (rst_n && dn_valid && dn_ready) begin
      n_xfer++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected transfer line", 64'(dn_line), 64'h0);
      end else begin
        xfer_t t;
        t = exp_q.pop_front();
        check(dn_line == t.line, "R8", "transfer line", 64'(dn_line), 64'(t.line));
        check((dn_data & t.dmask) == t.data, "R9", "transfer data",
              dn_data & t.dmask, t.data);
        check(dn_be == t.be, "R9", "transfer byte enables", 64'(dn_be), 64'(t.be));
      end
    end
  end

  function automatic logic [11:0] wa(input int line, input int off);
    return 12'(line * 4 + off);
  endfunction

  task automatic do_wr(input logic [11:0] a, input logic [15:0] d, input string req);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #3;
    check(wr_ready == 1'b1, req, "wr_ready on write", 64'(wr_ready), 64'h1);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // kind: 1 bypass, 2 forward, 4 stall, 0 idle
  task automatic chk_rd(input bit v, input logic [11:0] a, input logic [2:0] kind,
                        input logic [15:0] d, input string req);
    @(negedge clk);
    rd_valid = v; rd_addr = a;
    #3;
    check({rd_stall, rd_fwd, rd_bypass} == kind, req, "read outcome",
          64'({rd_stall, rd_fwd, rd_bypass}), 64'(kind));
    if (kind == 3'b010)
      check(rd_data == d, req, "forwarded data", 64'(rd_data), 64'(d));
    rd_valid = 1'b0;
  endtask

  task automatic probe_ready(input logic [11:0] a, input logic exp, input string req);
    @(negedge clk);
    wr_valid = 1'b0; wr_addr = a;
    #3;
    check(wr_ready == exp, req, "wr_ready probe", 64'(wr_ready), 64'(exp));
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      check(1'b0, "R1", "watchdog expired", 64'h0, 64'h1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    @(negedge clk); #3;
    check(dn_valid == 1'b0, "R1", "dn_valid after reset", 64'(dn_valid), 64'h0);
    check(wr_ready == 1'b1, "R1", "wr_ready after reset", 64'(wr_ready), 64'h1);
    chk_rd(1'b1, wa(16, 0), 3'b001, 16'h0, "R1");

    // fill two lines with downstream stalled
    do_wr(wa(16, 0), 16'hA001, "R2");
    do_wr(wa(16, 2), 16'hB002, "R2");
    do_wr(wa(33, 1), 16'hC003, "R2");
    chk_rd(1'b1, wa(16, 0), 3'b010, 16'hA001, "R4");
    chk_rd(1'b1, wa(16, 2), 3'b010, 16'hB002, "R4");
    chk_rd(1'b1, wa(16, 1), 3'b100, 16'h0, "R5");
    chk_rd(1'b1, wa(24, 0), 3'b100, 16'h0, "R3");   // same low 3 line bits as 16
    chk_rd(1'b1, wa(19, 0), 3'b001, 16'h0, "R3");   // low bits 3 match nothing
    do_wr(wa(16, 0), 16'hD004, "R2");
    chk_rd(1'b1, wa(16, 0), 3'b010, 16'hD004, "R4");
    chk_rd(1'b0, wa(16, 0), 3'b000, 16'h0, "R11");

    // R6: fill the buffer
    do_wr(wa(50, 3), 16'hE005, "R6");
    do_wr(wa(69, 0), 16'hF006, "R6");
    probe_ready(wa(119, 0), 1'b0, "R6");
    probe_ready(wa(33, 3), 1'b1, "R6");
    do_wr(wa(33, 3), 16'h1007, "R2");
    probe_ready(wa(119, 0), 1'b0, "R2");   // merge used no slot

    // R7/R8: bank 0 blocked, bank 1 slots drain first, then oldest-first
    push_exp(10'd33, 16'h0, 16'hC003, 16'h0, 16'h1007, 4'b1010);
    push_exp(10'd69, 16'hF006, 16'h0, 16'h0, 16'h0, 4'b0001);
    push_exp(10'd16, 16'hD004, 16'h0, 16'hB002, 16'h0, 4'b0101);
    push_exp(10'd50, 16'h0, 16'h0, 16'h0, 16'hE005, 4'b1000);
    @(negedge clk);
    dn_bank_busy = 2'b01; dn_ready = 1'b1;
    repeat (5) @(negedge clk);
    #3;
    check(n_xfer == 2, "R7", "transfers with bank 0 blocked", 64'(n_xfer), 64'd2);
    check(dn_valid == 1'b0, "R7", "dn_valid with only blocked slots", 64'(dn_valid), 64'h0);
    @(negedge clk);
    dn_bank_busy = 2'b00;
    repeat (5) @(negedge clk);
    #3;
    check(n_xfer == 4, "R8", "transfers after unblock", 64'(n_xfer), 64'd4);
    check(exp_q.size() == 0, "R8", "scoreboard drained", 64'(exp_q.size()), 64'd0);
    chk_rd(1'b1, wa(16, 0), 3'b001, 16'h0, "R9");   // slot freed

    // R10: write lands on the edge its line leaves
    @(negedge clk);
    dn_ready = 1'b0;
    do_wr(wa(80, 0), 16'h2008, "R10");
    push_exp(10'd80, 16'h2008, 16'h0, 16'h0, 16'h0, 4'b0001);
    push_exp(10'd80, 16'h0, 16'h3009, 16'h0, 16'h0, 4'b0010);
    @(negedge clk);
    dn_ready = 1'b1; wr_valid = 1'b1; wr_addr = wa(80, 1); wr_data = 16'h3009;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (4) @(negedge clk);
    #3;
    check(n_xfer == 6, "R10", "transfer count", 64'(n_xfer), 64'd6);
    check(exp_q.size() == 0, "R10", "scoreboard drained", 64'(exp_q.size()), 64'd0);
    chk_rd(1'b1, wa(80, 1), 3'b001, 16'h0, "R10");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule